// File: doc/BRIEF.md
# Transmit Bid Handshake

This block is the host-facing front end of a packet transmitter. The host has to win buffer space before it may send any frame data. It does this in two steps: a write to the command register arms a bid, and the next write to the length register commits it. The block checks the committed length. A bad length throws the bid away and sets an error flag. A good length becomes a granted bid at once if the buffer allocator reports free space. Otherwise the bid waits until space appears. A grant that had to wait also raises a ready event, and that event can drive an interrupt line.

Once a bid is granted, the host streams the frame as 16-bit word writes to a single data port. The block counts these words against the number the committed byte length needs. When the last word arrives, it pulses a completion output and drops the ready-now flag. Register reads are combinational on `rdata`. The read-to-clear side effects take hold at the clock edge that ends the read.

Top module: `tx_bid_hs`

## Requirements
- R1: After reset, the status register (0x138), the event register (0x12C) and the config register (0x116) all read zero, and `irq` and `frame_done` are low.
- R2: A write to the command register (0x144) arms a bid. It also cancels any pending or granted bid and restarts the word count. A write to the length register (0x146) with no armed bid changes nothing.
- R3: An armed length write of 0 or of more than 1514 discards the bid and sets the error flag (status bit 7). A read of the status register clears that flag.
- R4: An armed length write of 1..1514 while `space_avail` is high sets ready-now (status bit 8) at that clock edge and does not set the event flag.
- R5: An armed valid length write while `space_avail` is low leaves the bid pending. At the first edge where `space_avail` is high, ready-now and the event flag (event register bit 8) are both set.
- R6: A config write stores `wdata` bit 8 as the interrupt enable, which reads back at config bit 8. `irq` is high exactly when the event flag and the enable are both set.
- R7: A read of the event register clears the event flag. If a deferred grant lands in the same cycle, the flag stays set.
- R8: While ready-now is set, each write to the data port (0xA00) counts one word. The write that brings the count to ceil(length/2) makes `frame_done` high for the next cycle only and clears ready-now at that same edge.
- R9: A data-port write while ready-now is clear is not counted.
- R10: A command write in the same cycle that `space_avail` frees a pending bid cancels the bid: neither ready-now nor the event flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host register offset |
| wdata | input | DATA_W | Host write data |
| space_avail | input | 1 | Buffer allocator reports room for the bid |
| rdata | output | DATA_W | Read data for the addressed register (combinational) |
| irq | output | 1 | Ready-event interrupt |
| frame_done | output | 1 | One-cycle pulse after the last frame word |

## Verification
Two same-cycle collisions matter most. The first is a deferred grant, where a pending bid meets free space, in the same cycle as a host read of the event register. The second is a grant in the same cycle as a command write. The bench provokes both by holding a bid pending and then raising `space_avail` in the cycle that carries the read or the command write. A behavioural model, stepped every clock, judges the result. The model expects the event flag to survive the read, and expects the command write to leave no ready-now and no event. The status and event reads that follow confirm both outcomes at the ports.

// File: rtl/tx_bid_pkg.sv
// Package: register offsets and the decoded host operation type shared by
// the transmit bid handshake modules. Offsets are word-aligned byte offsets.
package tx_bid_pkg;

    localparam logic [11:0] OFF_STATUS = 12'h138;
    localparam logic [11:0] OFF_EVENT  = 12'h12C;
    localparam logic [11:0] OFF_CONFIG = 12'h116;
    localparam logic [11:0] OFF_CMD    = 12'h144;
    localparam logic [11:0] OFF_LEN    = 12'h146;
    localparam logic [11:0] OFF_DATA   = 12'hA00;

    localparam int ERR_BIT   = 7;
    localparam int READY_BIT = 8;
    localparam int EVENT_BIT = 8;
    localparam int IE_BIT    = 8;

    // One strobe per kind of host access; at most one is set per cycle.
    typedef struct packed {
        logic cmd_wr;
        logic len_wr;
        logic cfg_wr;
        logic data_wr;
        logic stat_rd;
        logic evt_rd;
    } host_op_t;

endpackage

// File: rtl/tx_bid_decode.sv
// Module: tx_bid_decode
// Turns a host strobe and offset into one-hot access strobes.
// Assumes wr_en and rd_en are never high together.
module tx_bid_decode
    import tx_bid_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output host_op_t          op
);

    // Compare the offset against each register location.
    always_comb begin
        op         = '0;
        op.cmd_wr  = wr_en && (addr == ADDR_W'(OFF_CMD));
        op.len_wr  = wr_en && (addr == ADDR_W'(OFF_LEN));
        op.cfg_wr  = wr_en && (addr == ADDR_W'(OFF_CONFIG));
        op.data_wr = wr_en && (addr == ADDR_W'(OFF_DATA));
        op.stat_rd = rd_en && (addr == ADDR_W'(OFF_STATUS));
        op.evt_rd  = rd_en && (addr == ADDR_W'(OFF_EVENT));
    end

endmodule

// File: rtl/tx_bid_ctrl.sv
// Module: tx_bid_ctrl
// Bid state: arming, length checking, immediate or deferred grant, error
// flag, ready event and interrupt enable.
// Assumes frame_last is asserted only while rdy_now is high.
module tx_bid_ctrl
    import tx_bid_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MAX_LEN = 1514,
    parameter int CNT_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  host_op_t          op,
    input  logic [DATA_W-1:0] wdata,
    input  logic              space_avail,
    input  logic              frame_last,
    output logic              armed,
    output logic              pending,
    output logic              rdy_now,
    output logic              bid_err,
    output logic              evt,
    output logic              ie_en,
    output logic              commit,
    output logic [CNT_W-1:0]  need_words
);

    logic              len_bad;
    logic              grant;
    logic [DATA_W:0]   half_len;

    // Classify the length on the bus and derive the commit and grant events.
    always_comb begin
        len_bad    = (wdata == '0) || (wdata > DATA_W'(MAX_LEN));
        commit     = op.len_wr && armed && !len_bad;
        grant      = pending && space_avail && !op.cmd_wr;
        half_len   = ({1'b0, wdata} + (DATA_W+1)'(1)) >> 1;
        need_words = half_len[CNT_W-1:0];
    end

    // Arm on a command write; a length write uses up the arming.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed <= 1'b0;
        else if (op.cmd_wr)  armed <= 1'b1;
        else if (op.len_wr)  armed <= 1'b0;
    end

    // Hold a valid bid that found no space, until a grant or cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pending <= 1'b0;
        else if (op.cmd_wr)              pending <= 1'b0;
        else if (commit && !space_avail) pending <= 1'b1;
        else if (grant)                  pending <= 1'b0;
    end

    // Ready-now: set by an immediate or deferred grant, cleared by the last word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rdy_now <= 1'b0;
        else if (op.cmd_wr)                        rdy_now <= 1'b0;
        else if ((commit && space_avail) || grant) rdy_now <= 1'b1;
        else if (frame_last)                       rdy_now <= 1'b0;
    end

    // Error flag: set by a rejected length, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                           bid_err <= 1'b0;
        else if (op.len_wr && armed && len_bad) bid_err <= 1'b1;
        else if (op.stat_rd)                  bid_err <= 1'b0;
    end

    // Event flag: a deferred grant sets it and wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)         evt <= 1'b0;
        else if (grant)     evt <= 1'b1;
        else if (op.evt_rd) evt <= 1'b0;
    end

    // Interrupt enable taken from the config write.
    always_ff @(posedge clk) begin
        if (!rst_n)         ie_en <= 1'b0;
        else if (op.cfg_wr) ie_en <= wdata[IE_BIT];
    end

endmodule

// File: rtl/tx_word_count.sv
// Module: tx_word_count
// Counts accepted frame words against the target loaded at commit time and
// flags the last one. Assumes the target is at least one word.
module tx_word_count #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_words,
    input  logic             accept,
    output logic             last,
    output logic             done
);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] target;

    // The accepted word completes the frame when it reaches the target.
    always_comb last = accept && ((count + CNT_W'(1)) == target);

    // Track words taken so far; restart on cancel, new bid or completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            target <= '0;
        end else if (clear) begin
            count  <= '0;
        end else if (load) begin
            count  <= '0;
            target <= load_words;
        end else if (accept) begin
            count  <= last ? '0 : count + CNT_W'(1);
        end
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last;
    end

endmodule

// File: rtl/tx_bid_hs.sv
// Module: tx_bid_hs (top)
// Host-side transmit bid handshake: decode, bid control, word counting and
// the combinational read mux. Assumes one host access per cycle.
module tx_bid_hs
    import tx_bid_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 16,
    parameter int MAX_LEN = 1514
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              space_avail,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              frame_done
);

    localparam int MAX_WORDS = (MAX_LEN + 1) / 2;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);

    host_op_t         op;
    logic             armed;
    logic             pending;
    logic             rdy_now;
    logic             bid_err;
    logic             evt;
    logic             ie_en;
    logic             commit;
    logic             frame_last;
    logic [CNT_W-1:0] need_words;

    tx_bid_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .op    (op)
    );

    tx_bid_ctrl #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .wdata       (wdata),
        .space_avail (space_avail),
        .frame_last  (frame_last),
        .armed       (armed),
        .pending     (pending),
        .rdy_now     (rdy_now),
        .bid_err     (bid_err),
        .evt         (evt),
        .ie_en       (ie_en),
        .commit      (commit),
        .need_words  (need_words)
    );

    tx_word_count #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (op.cmd_wr),
        .load       (commit),
        .load_words (need_words),
        .accept     (op.data_wr && rdy_now),
        .last       (frame_last),
        .done       (frame_done)
    );

    // Read mux for the three readable registers; other offsets read zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(OFF_STATUS)) begin
                rdata[ERR_BIT]   = bid_err;
                rdata[READY_BIT] = rdy_now;
            end else if (addr == ADDR_W'(OFF_EVENT)) begin
                rdata[EVENT_BIT] = evt;
            end else if (addr == ADDR_W'(OFF_CONFIG)) begin
                rdata[IE_BIT]    = ie_en;
            end
        end
    end

    // Interrupt request from the enabled event.
    always_comb irq = evt && ie_en;

endmodule

// File: rtl/tx_bid_hs_chk.sv
// Module: tx_bid_hs_chk
// Property checker for tx_bid_hs, attached by bind below.
module tx_bid_hs_chk
    import tx_bid_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 16,
    parameter int MAX_LEN = 1514
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              space_avail,
    input logic              frame_done,
    input logic              armed,
    input logic              pending,
    input logic              rdy_now,
    input logic              bid_err,
    input logic              evt
);

    p_bad_len_sets_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_LEN) && armed &&
         (wdata == '0 || wdata > DATA_W'(MAX_LEN))) |=> bid_err);

    p_cmd_cancels_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_CMD)) |=> (!rdy_now && !pending));

    p_event_from_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt) |-> $past(pending));

    p_ready_excludes_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdy_now && pending));

    p_read_clears_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFF_EVENT) && !(pending && space_avail)) |=> !evt);

    p_done_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !rdy_now);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

endmodule

bind tx_bid_hs tx_bid_hs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .space_avail (space_avail),
    .frame_done  (frame_done),
    .armed       (armed),
    .pending     (pending),
    .rdy_now     (rdy_now),
    .bid_err     (bid_err),
    .evt         (evt)
);

// File: tb/tx_bid_hs_test.sv
// Bench: behavioural reference model stepped every clock and compared with
// rdata (on reads), irq and frame_done.
module tx_bid_hs_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_STAT = 12'h138;
    localparam logic [11:0] A_EVT  = 12'h12C;
    localparam logic [11:0] A_CFG  = 12'h116;
    localparam logic [11:0] A_CMD  = 12'h144;
    localparam logic [11:0] A_LEN  = 12'h146;
    localparam logic [11:0] A_DATA = 12'hA00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        space_avail = 1'b0;
    logic [15:0] rdata;
    logic        irq;
    logic        frame_done;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    int m_armed = 0, m_pend = 0, m_rdy = 0, m_err = 0, m_evt = 0, m_ie = 0;
    int m_need = 0, m_cnt = 0, m_done = 0;

    tx_bid_hs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .space_avail(space_avail), .rdata(rdata), .irq(irq),
        .frame_done(frame_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int model_read(input logic [11:0] a);
        if (a == A_STAT) return (m_rdy << 8) | (m_err << 7);
        if (a == A_EVT)  return m_evt << 8;
        if (a == A_CFG)  return m_ie << 8;
        return 0;
    endfunction

    // Advance the model by one clock edge using the inputs of that cycle.
    task automatic model_step(input bit w, input bit r, input logic [11:0] a,
                              input int d, input bit sp);
        int grant;
        grant  = (m_pend != 0 && sp && !(w && a == A_CMD)) ? 1 : 0;
        m_done = 0;
        if (grant != 0) begin
            m_pend = 0; m_rdy = 1; m_evt = 1;
        end
        if (w) begin
            if (a == A_CMD) begin
                m_armed = 1; m_pend = 0; m_rdy = 0; m_cnt = 0;
            end else if (a == A_LEN && m_armed != 0) begin
                m_armed = 0;
                if (d == 0 || d > 1514) m_err = 1;
                else begin
                    m_need = (d + 1) / 2; m_cnt = 0;
                    if (sp) m_rdy = 1; else m_pend = 1;
                end
            end else if (a == A_CFG) begin
                m_ie = (d >> 8) & 1;
            end else if (a == A_DATA && m_rdy != 0) begin
                if (m_cnt + 1 == m_need) begin
                    m_done = 1; m_rdy = 0; m_cnt = 0;
                end else m_cnt++;
            end
        end
        if (r) begin
            if (a == A_STAT) m_err = 0;
            if (a == A_EVT && grant == 0) m_evt = 0;
        end
    endtask

    // One bus cycle: drive, compare read data, clock, compare outputs.
    task automatic cyc(input bit w, input bit r, input logic [11:0] a,
                       input int d, input bit sp, input string tag);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = 16'(d); space_avail = sp;
        #1;
        if (r) check(tag, "rdata", int'(rdata), model_read(a));
        @(posedge clk);
        model_step(w, r, a, d, sp);
        #1;
        check(tag, "irq", int'(irq), m_evt & m_ie);
        check(tag, "frame_done", int'(frame_done), m_done);
    endtask

    task automatic wr(input logic [11:0] a, input int d, input bit sp, input string tag);
        cyc(1'b1, 1'b0, a, d, sp, tag);
    endtask

    task automatic rd(input logic [11:0] a, input bit sp, input string tag);
        cyc(1'b0, 1'b1, a, 0, sp, tag);
    endtask

    task automatic send_words(input int n, input string tag);
        for (int i = 0; i < n; i++) wr(A_DATA, i, 1'b1, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1", "irq", int'(irq), 0);
        check("R1", "frame_done", int'(frame_done), 0);
        rd(A_STAT, 1'b0, "R1");
        rd(A_EVT, 1'b0, "R1");
        rd(A_CFG, 1'b0, "R1");

        // R2: length without an armed bid does nothing
        wr(A_LEN, 10, 1'b1, "R2");
        rd(A_STAT, 1'b1, "R2");
        wr(A_DATA, 1, 1'b1, "R2");

        // R3: zero length, then over-long length
        wr(A_CMD, 0, 1'b1, "R3");
        wr(A_LEN, 0, 1'b1, "R3");
        rd(A_STAT, 1'b1, "R3");
        rd(A_STAT, 1'b1, "R3");
        wr(A_CMD, 0, 1'b1, "R3");
        wr(A_LEN, 1515, 1'b1, "R3");
        rd(A_STAT, 1'b1, "R3");

        // R4 and R8: maximum length granted at once, full frame
        wr(A_CMD, 0, 1'b1, "R4");
        wr(A_LEN, 1514, 1'b1, "R4");
        rd(A_STAT, 1'b1, "R4");
        rd(A_EVT, 1'b1, "R4");
        send_words(757, "R8");
        rd(A_STAT, 1'b1, "R8");
        cyc(1'b0, 1'b0, A_STAT, 0, 1'b1, "R8");

        // R8: odd length 5 needs three words
        wr(A_CMD, 0, 1'b1, "R8");
        wr(A_LEN, 5, 1'b1, "R8");
        send_words(3, "R8");
        rd(A_STAT, 1'b1, "R8");

        // R9: words outside a grant are not counted
        send_words(3, "R9");
        wr(A_CMD, 0, 1'b1, "R9");
        wr(A_LEN, 4, 1'b1, "R9");
        send_words(2, "R9");
        rd(A_STAT, 1'b1, "R9");

        // R5 and R6: deferred grant with interrupt enabled
        wr(A_CFG, 16'h0100, 1'b0, "R6");
        rd(A_CFG, 1'b0, "R6");
        wr(A_CMD, 0, 1'b0, "R5");
        wr(A_LEN, 10, 1'b0, "R5");
        rd(A_STAT, 1'b0, "R5");
        cyc(1'b0, 1'b0, A_STAT, 0, 1'b0, "R5");
        cyc(1'b0, 1'b0, A_STAT, 0, 1'b1, "R5");
        rd(A_STAT, 1'b1, "R5");
        rd(A_EVT, 1'b1, "R7");
        rd(A_EVT, 1'b1, "R7");
        send_words(5, "R8");

        // R7: grant collides with an event read, set wins
        wr(A_CMD, 0, 1'b0, "R7");
        wr(A_LEN, 2, 1'b0, "R7");
        rd(A_EVT, 1'b1, "R7");
        rd(A_EVT, 1'b0, "R7");
        wr(A_CFG, 0, 1'b0, "R6");
        rd(A_EVT, 1'b0, "R6");

        // R10: grant collides with a command write, cancel wins
        wr(A_CMD, 0, 1'b0, "R10");
        wr(A_LEN, 8, 1'b0, "R10");
        wr(A_CMD, 0, 1'b1, "R10");
        rd(A_STAT, 1'b1, "R10");
        rd(A_EVT, 1'b1, "R10");

        // R2: command write cancels a granted bid
        wr(A_LEN, 6, 1'b1, "R2");
        wr(A_DATA, 0, 1'b1, "R2");
        wr(A_CMD, 0, 1'b1, "R2");
        rd(A_STAT, 1'b1, "R2");
        send_words(2, "R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule